// File: doc/BRIEF.md
# LCD Interrupt Status Controller

This block collects the interrupt events of a display controller that fetches frames over seven DMA channels. Each cycle it accepts at most one frame event (start of frame, end of frame, branch taken or bus error), tagged with a channel number. Start-of-frame and end-of-frame events also carry the channel's current command word, and every event carries the channel's frame identifier. Two further inputs come from the rest of the controller: a last-frame-done strobe and the enable bit of the software control word.

Events on channel 0 set bits in a primary status word. Events on channels 1 to 6 set bits in a secondary status word, which has its own mask word with the same bit layout. Software masks primary sources through the upper half of a control word and clears status by writing ones. The block keeps the frame identifier of the last event that raised a bus error or a subsequent-interrupt flag. It drives one registered, level-sensitive interrupt line.

A subsequent-interrupt flag records that an unmasked event arrived while the line was already high. Software uses it to detect that it has missed events.

Top module: `lcd_irq_status`

## Requirements
- R1: After reset the control word, secondary mask, both status words, the frame identifier and `irq_o` are all zero.
- R2: A start-of-frame event (`ev_kind`=0) is recorded only if bit 22 of `ev_cmd` is 1. On channel 0 it sets primary bit 1. On channel c (1..6) it sets secondary bit c-1.
- R3: An end-of-frame event (`ev_kind`=1) is recorded only if bit 21 of `ev_cmd` is 1. On channel 0 it sets primary bit 8. On channel c it sets secondary bit c+7.
- R4: A branch event (`ev_kind`=2) is always recorded. On channel 0 it sets primary bit 9. On channel c it sets secondary bit c+15.
- R5: A bus-error event (`ev_kind`=3) sets primary bit 2, writes the channel number into primary bits 30:28 and loads `ev_fid` into `frame_id_o`.
- R6: `irq_o` is computed from the register state and is itself registered, so it follows a status or mask change one cycle later. It is high when any of these holds:
  - a primary bit i in {0,1,4,6,7,8,9,11,12} is set while control bit 16+i is clear;
  - primary bit 5 is set while secondary mask bit 24 is clear;
  - any secondary bit is set while the same secondary mask bit is clear.
- R7: Primary bit 10 is set, and `frame_id_o` takes `ev_fid`, in two cases:
  - a recorded start-of-frame, end-of-frame or branch event is unmasked (control bit 16+i for channel 0, the matching secondary mask bit otherwise) while `irq_o` is 1;
  - a bus error arrives while `irq_o` is 1.
- R8: A write with `wr_sel`=2 clears the primary bits written as 1 within bits 11:0. Writing 1 to bit 2 also clears bits 30:28.
- R9: A write with `wr_sel`=3 clears the secondary bits written as 1, but only within 0x003E3F3F. Bit 16 and bits 29:22 cannot be cleared.
- R10: A control write (`wr_sel`=0) that takes bit 0 from 1 to 0 sets primary bit 7. A pulse on `last_frame_done` sets primary bit 0.
- R11: When an event sets a status bit in the same cycle as a write clears it, the bit ends up set.
- R12: An event whose channel number is NCH or above changes no status bit and does not change the frame identifier.
- R13: A control write (`wr_sel`=0) keeps only bits 0 and 28:16. A secondary-mask write (`wr_sel`=1) keeps only the bits of 0x3F3F3F3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 secondary mask, 2 primary status, 3 secondary status |
| wr_data | input | 32 | Write data |
| ev_valid | input | 1 | Frame event strobe |
| ev_kind | input | 2 | 0 start of frame, 1 end of frame, 2 branch, 3 bus error |
| ev_ch | input | 3 | Channel that raised the event |
| ev_cmd | input | 32 | Current command word of that channel |
| ev_fid | input | FID_W | Frame identifier of that channel |
| last_frame_done | input | 1 | Last-frame-done strobe |
| ctrl_o | output | 32 | Control word: enable bit and primary masks |
| sec_mask_o | output | 32 | Secondary mask word |
| pri_status_o | output | 32 | Primary status word |
| sec_status_o | output | 32 | Secondary status word |
| frame_id_o | output | FID_W | Captured frame identifier |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the block sees at most one frame event per cycle and that the event fields are meaningful only while `ev_valid` is high. The port shape enforces the first assumption, and the stimulus respects both. The assertions do not assume that channel numbers are in range or that writes and events are kept apart. For that reason the random stimulus draws channel numbers from 0 to 7, so the unused channel 7 occurs, and it lets events, writes and the last-frame-done strobe coincide freely. The directed cases place a set and a clear of the same bit in one cycle, and also try to clear bits that the requirements protect.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        EV_SOF    = 2'd0,
        EV_EOF    = 2'd1,
        EV_BRANCH = 2'd2,
        EV_BUSERR = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_SMASK = 2'd1,
        SEL_PSTAT = 2'd2,
        SEL_SSTAT = 2'd3
    } reg_sel_e;

    // primary status bit positions
    localparam int P_LDD    = 0;
    localparam int P_SOF0   = 1;
    localparam int P_BER    = 2;
    localparam int P_IU1    = 5;
    localparam int P_QD     = 7;
    localparam int P_EOF0   = 8;
    localparam int P_BS0    = 9;
    localparam int P_SINT   = 10;
    localparam int P_CH_LO  = 28;
    localparam int P_NSRC   = 13;

    // control word layout
    localparam int C_EN      = 0;
    localparam int C_MASK_LO = 16;

    // secondary bit offsets relative to the channel number
    localparam int S_SOF_OFS = -1;
    localparam int S_EOF_OFS = 7;
    localparam int S_BS_OFS  = 15;
    localparam int S_IU1_MSK = 24;

    // command word gating bits
    localparam int CMD_SOF = 22;
    localparam int CMD_EOF = 21;

    localparam logic [DW-1:0]      CTRL_KEEP  = 32'h1FFF_0001;
    localparam logic [DW-1:0]      SMASK_KEEP = 32'h3F3F_3F3F;
    localparam logic [DW-1:0]      PSTAT_W1C  = 32'h0000_0FFF;
    localparam logic [DW-1:0]      PCH_FIELD  = 32'h7000_0000;
    localparam logic [DW-1:0]      SSTAT_W1C  = 32'h003E_3F3F;
    localparam logic [P_NSRC-1:0]  PRI_SRC    = 13'h1BD3;

endpackage

// File: rtl/lcd_irq_evdec.sv
module lcd_irq_evdec
    import lcd_irq_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic          ev_valid,
    input  logic [1:0]    ev_kind,
    input  logic [2:0]    ev_ch,
    input  logic [DW-1:0] ev_cmd,
    input  logic [DW-1:0] ctrl_q,
    input  logic [DW-1:0] smask_q,
    input  logic          irq_q,
    output logic [DW-1:0] pri_set,
    output logic [DW-1:0] sec_set,
    output logic          ber_hit,
    output logic [2:0]    ber_ch,
    output logic          fid_load
);

    logic       ch_ok;
    logic       is_ch0;
    logic       hit;
    logic       unmasked;
    logic [4:0] sec_idx;
    logic [4:0] pri_idx;
    logic       unused_cmd_bits;

    assign unused_cmd_bits = ^{ev_cmd[DW-1:CMD_SOF+1], ev_cmd[CMD_EOF-1:0]};
    assign ch_ok  = ev_valid && (32'(ev_ch) < NCH);
    assign is_ch0 = (ev_ch == 3'd0);
    assign ber_ch = ev_ch;

    always_comb begin
        hit      = 1'b0;
        ber_hit  = 1'b0;
        sec_idx  = '0;
        pri_idx  = '0;
        case (ev_kind_e'(ev_kind))
            EV_SOF: begin
                hit     = ev_cmd[CMD_SOF];
                pri_idx = 5'(P_SOF0);
                sec_idx = 5'({2'b00, ev_ch} + 5'(S_SOF_OFS));
            end
            EV_EOF: begin
                hit     = ev_cmd[CMD_EOF];
                pri_idx = 5'(P_EOF0);
                sec_idx = 5'({2'b00, ev_ch} + 5'(S_EOF_OFS));
            end
            EV_BRANCH: begin
                hit     = 1'b1;
                pri_idx = 5'(P_BS0);
                sec_idx = 5'({2'b00, ev_ch} + 5'(S_BS_OFS));
            end
            EV_BUSERR: begin
                hit     = 1'b1;
                ber_hit = ch_ok;
                pri_idx = 5'(P_BER);
            end
            default: hit = 1'b0;
        endcase
        hit = hit && ch_ok;
    end

    always_comb begin
        pri_set  = '0;
        sec_set  = '0;
        unmasked = 1'b0;
        fid_load = 1'b0;
        if (hit) begin
            if (ber_hit) begin
                pri_set[P_BER] = 1'b1;
                unmasked       = 1'b1;
                fid_load       = 1'b1;
            end else if (is_ch0) begin
                pri_set[pri_idx] = 1'b1;
                unmasked         = !ctrl_q[C_MASK_LO + 32'(pri_idx)];
            end else begin
                sec_set[sec_idx] = 1'b1;
                unmasked         = !smask_q[sec_idx];
            end
            if (unmasked && irq_q) begin
                pri_set[P_SINT] = 1'b1;
                fid_load        = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_irq_wrdec.sv
module lcd_irq_wrdec
    import lcd_irq_pkg::*;
(
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          en_q,
    output logic          ctrl_we,
    output logic [DW-1:0] ctrl_wdata,
    output logic          smask_we,
    output logic [DW-1:0] smask_wdata,
    output logic [DW-1:0] pri_clr,
    output logic [DW-1:0] sec_clr,
    output logic          qd_set
);

    always_comb begin
        ctrl_we     = 1'b0;
        smask_we    = 1'b0;
        pri_clr     = '0;
        sec_clr     = '0;
        qd_set      = 1'b0;
        ctrl_wdata  = wr_data & CTRL_KEEP;
        smask_wdata = wr_data & SMASK_KEEP;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    ctrl_we = 1'b1;
                    qd_set  = en_q && !wr_data[C_EN];
                end
                SEL_SMASK: smask_we = 1'b1;
                SEL_PSTAT: begin
                    pri_clr = wr_data & PSTAT_W1C;
                    if (wr_data[P_BER]) begin
                        pri_clr = pri_clr | PCH_FIELD;
                    end
                end
                SEL_SSTAT: sec_clr = wr_data & SSTAT_W1C;
                default: ctrl_we = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lcd_irq_reduce.sv
module lcd_irq_reduce
    import lcd_irq_pkg::*;
(
    input  logic [P_NSRC-1:0] pri_src,
    input  logic [P_NSRC-1:0] pri_mask,
    input  logic [DW-1:0]     sec_stat,
    input  logic [DW-1:0]     sec_mask,
    output logic              irq_raw
);

    logic [P_NSRC-1:0] pri_hit;

    for (genvar i = 0; i < P_NSRC; i++) begin : g_src
        if (i == P_IU1) begin : g_iu1
            assign pri_hit[i] = pri_src[i] && !sec_mask[S_IU1_MSK];
        end else if (PRI_SRC[i]) begin : g_on
            assign pri_hit[i] = pri_src[i] && !pri_mask[i];
        end else begin : g_off
            assign pri_hit[i] = 1'b0;
        end
    end

    assign irq_raw = (|pri_hit) || (|(sec_stat & ~sec_mask));

endmodule

// File: rtl/lcd_irq_status.sv
module lcd_irq_status
    import lcd_irq_pkg::*;
#(
    parameter int NCH   = 7,
    parameter int FID_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             ev_valid,
    input  logic [1:0]       ev_kind,
    input  logic [2:0]       ev_ch,
    input  logic [31:0]      ev_cmd,
    input  logic [FID_W-1:0] ev_fid,
    input  logic             last_frame_done,
    output logic [31:0]      ctrl_o,
    output logic [31:0]      sec_mask_o,
    output logic [31:0]      pri_status_o,
    output logic [31:0]      sec_status_o,
    output logic [FID_W-1:0] frame_id_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [DW-1:0]    ctrl;
        logic [DW-1:0]    smask;
        logic [DW-1:0]    pri;
        logic [DW-1:0]    sec;
        logic [FID_W-1:0] fid;
        logic             irq;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0] pri_set, sec_set, pri_clr, sec_clr;
    logic [DW-1:0] ctrl_wdata, smask_wdata;
    logic          ber_hit, fid_load, ctrl_we, smask_we, qd_set, irq_raw;
    logic [2:0]    ber_ch;

    lcd_irq_evdec #(.NCH(NCH)) u_evdec (
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .ev_ch    (ev_ch),
        .ev_cmd   (ev_cmd),
        .ctrl_q   (st_q.ctrl),
        .smask_q  (st_q.smask),
        .irq_q    (st_q.irq),
        .pri_set  (pri_set),
        .sec_set  (sec_set),
        .ber_hit  (ber_hit),
        .ber_ch   (ber_ch),
        .fid_load (fid_load)
    );

    lcd_irq_wrdec u_wrdec (
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .en_q        (st_q.ctrl[C_EN]),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .smask_we    (smask_we),
        .smask_wdata (smask_wdata),
        .pri_clr     (pri_clr),
        .sec_clr     (sec_clr),
        .qd_set      (qd_set)
    );

    lcd_irq_reduce u_reduce (
        .pri_src  (st_q.pri[P_NSRC-1:0]),
        .pri_mask (st_q.ctrl[C_MASK_LO +: P_NSRC]),
        .sec_stat (st_q.sec),
        .sec_mask (st_q.smask),
        .irq_raw  (irq_raw)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctrl = ctrl_wdata;
        end
        if (smask_we) begin
            st_d.smask = smask_wdata;
        end
        // set wins over a clear in the same cycle
        st_d.pri = (st_q.pri & ~pri_clr) | pri_set;
        st_d.pri[P_QD]  = st_d.pri[P_QD]  | qd_set;
        st_d.pri[P_LDD] = st_d.pri[P_LDD] | last_frame_done;
        if (ber_hit) begin
            st_d.pri[P_CH_LO +: 3] = ber_ch;
        end
        st_d.sec = (st_q.sec & ~sec_clr) | sec_set;
        if (fid_load) begin
            st_d.fid = ev_fid;
        end
        st_d.irq = irq_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o       = st_q.ctrl;
    assign sec_mask_o   = st_q.smask;
    assign pri_status_o = st_q.pri;
    assign sec_status_o = st_q.sec;
    assign frame_id_o   = st_q.fid;
    assign irq_o        = st_q.irq;

endmodule

// File: rtl/lcd_irq_chk.sv
module lcd_irq_chk #(
    parameter int NCH   = 7,
    parameter int FID_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [31:0]      wr_data,
    input logic             ev_valid,
    input logic [1:0]       ev_kind,
    input logic [2:0]       ev_ch,
    input logic [31:0]      ev_cmd,
    input logic [FID_W-1:0] ev_fid,
    input logic             last_frame_done,
    input logic [31:0]      ctrl_o,
    input logic [31:0]      sec_mask_o,
    input logic [31:0]      pri_status_o,
    input logic [31:0]      sec_status_o,
    input logic [FID_W-1:0] frame_id_o,
    input logic             irq_o
);

    logic ch_in;
    logic unused_chk;
    assign ch_in      = 32'(ev_ch) < NCH;
    assign unused_chk = ^{wr_data, ev_cmd, sec_mask_o};

    AST_SOF_CH0_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_kind == 2'd0 && ev_ch == 3'd0 && ev_cmd[22] |=> pri_status_o[1]); // R2

    AST_EOF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_kind == 2'd1 && ev_ch == 3'd0 && !ev_cmd[21] && !pri_status_o[8]
        |=> !pri_status_o[8]); // R3

    AST_BRANCH_CH3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_kind == 2'd2 && ev_ch == 3'd3 |=> sec_status_o[18]); // R4

    AST_BUSERR_REC: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_kind == 2'd3 && ch_in
        |=> pri_status_o[2] && pri_status_o[30:28] == $past(ev_ch)
            && frame_id_o == $past(ev_fid)); // R5

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pri_status_o == 32'd0 && sec_status_o == 32'd0 |=> !irq_o); // R6

    AST_SINT_ON_BER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && ev_valid && ev_kind == 2'd3 && ch_in |=> pri_status_o[10]); // R7

    AST_SEC16_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sec_status_o[16] |=> sec_status_o[16]); // R9

    AST_QD_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd0 && ctrl_o[0] && !wr_data[0] |=> pri_status_o[7]); // R10

    AST_LDD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        last_frame_done |=> pri_status_o[0]); // R10

    AST_SET_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd2 && wr_data[9] && ev_valid && ev_kind == 2'd2 && ev_ch == 3'd0
        |=> pri_status_o[9]); // R11

    AST_BAD_CH_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ch_in && !wr_en && !last_frame_done
        |=> $stable(pri_status_o) && $stable(sec_status_o) && $stable(frame_id_o)); // R12

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd0 |=> (ctrl_o & ~32'h1FFF_0001) == 32'd0); // R13

endmodule

bind lcd_irq_status lcd_irq_chk #(.NCH(NCH), .FID_W(FID_W)) u_chk (.*);

// File: tb/lcd_irq_status_tb.sv
module lcd_irq_status_tb;

    localparam int NCH   = 7;
    localparam int FID_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_kind = '0;
    logic [2:0]  ev_ch = '0;
    logic [31:0] ev_cmd = '0;
    logic [31:0] ev_fid = '0;
    logic        last_frame_done = 1'b0;
    logic [31:0] ctrl_o, sec_mask_o, pri_status_o, sec_status_o, frame_id_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_err = 0;
    int cycles = 0;

    // reference state
    logic [31:0] m_ctrl, m_smask, m_pri, m_sec, m_fid;
    logic        m_irq;

    always #5 clk = ~clk;

    lcd_irq_status #(.NCH(NCH), .FID_W(FID_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_ch(ev_ch), .ev_cmd(ev_cmd),
        .ev_fid(ev_fid), .last_frame_done(last_frame_done), .ctrl_o(ctrl_o),
        .sec_mask_o(sec_mask_o), .pri_status_o(pri_status_o), .sec_status_o(sec_status_o),
        .frame_id_o(frame_id_o), .irq_o(irq_o)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic irq_of(logic [31:0] pri, logic [31:0] sec,
                                    logic [31:0] ctl, logic [31:0] sm);
        logic [12:0] src = 13'h1BD3;
        logic r = |(sec & ~sm);
        for (int i = 0; i < 13; i++) begin
            if (src[i] && pri[i] && !ctl[16+i]) r = 1'b1;
        end
        if (pri[5] && !sm[24]) r = 1'b1;
        return r;
    endfunction

    task automatic model_update();
        logic [31:0] pset = '0, sset = '0, pclr = '0, sclr = '0;
        logic        irq_n, unm = 1'b0, rec = 1'b0, take = 1'b0;
        int          c = int'(ev_ch);
        irq_n = irq_of(m_pri, m_sec, m_ctrl, m_smask);
        if (ev_valid && c < NCH) begin
            case (ev_kind)
                2'd0: if (ev_cmd[22]) begin
                    rec = 1'b1;
                    if (c == 0) begin pset[1] = 1'b1; unm = !m_ctrl[17]; end
                    else begin sset[c-1] = 1'b1; unm = !m_smask[c-1]; end
                end
                2'd1: if (ev_cmd[21]) begin
                    rec = 1'b1;
                    if (c == 0) begin pset[8] = 1'b1; unm = !m_ctrl[24]; end
                    else begin sset[c+7] = 1'b1; unm = !m_smask[c+7]; end
                end
                2'd2: begin
                    rec = 1'b1;
                    if (c == 0) begin pset[9] = 1'b1; unm = !m_ctrl[25]; end
                    else begin sset[c+15] = 1'b1; unm = !m_smask[c+15]; end
                end
                default: begin
                    rec = 1'b1; unm = 1'b1; take = 1'b1; pset[2] = 1'b1;
                end
            endcase
            if (rec && unm && m_irq) begin pset[10] = 1'b1; take = 1'b1; end
        end
        if (last_frame_done) pset[0] = 1'b1;
        if (wr_en) begin
            case (wr_sel)
                2'd0: begin
                    if (m_ctrl[0] && !wr_data[0]) pset[7] = 1'b1;
                    m_ctrl = wr_data & 32'h1FFF_0001;
                end
                2'd1: m_smask = wr_data & 32'h3F3F_3F3F;
                2'd2: begin
                    pclr = wr_data & 32'h0000_0FFF;
                    if (wr_data[2]) pclr |= 32'h7000_0000;
                end
                default: sclr = wr_data & 32'h003E_3F3F;
            endcase
        end
        m_pri = (m_pri & ~pclr) | pset;
        if (ev_valid && c < NCH && ev_kind == 2'd3) m_pri[30:28] = ev_ch;
        m_sec = (m_sec & ~sclr) | sset;
        if (take) m_fid = ev_fid;
        m_irq = irq_n;
    endtask

    task automatic idle();
        wr_en = 1'b0; ev_valid = 1'b0; last_frame_done = 1'b0;
    endtask

    task automatic compare_all();
        chk("R13 ctrl", ctrl_o, m_ctrl);
        chk("R13 smask", sec_mask_o, m_smask);
        chk("R8 primary", pri_status_o, m_pri);
        chk("R9 secondary", sec_status_o, m_sec);
        chk("R5 frame id", frame_id_o, m_fid);
        chk("R6 irq", {31'd0, irq_o}, {31'd0, m_irq});
    endtask

    task automatic step();
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic ev(input logic [1:0] k, input logic [2:0] ch,
                      input logic [31:0] cmd, input logic [31:0] fid);
        ev_valid = 1'b1; ev_kind = k; ev_ch = ch; ev_cmd = cmd; ev_fid = fid;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
    endtask

    initial begin
        int seed_ret;
        logic [31:0] hold;
        seed_ret = $urandom(32'd7315);
        m_ctrl = '0; m_smask = '0; m_pri = '0; m_sec = '0; m_fid = '0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1 primary", pri_status_o, 32'd0);
        chk("R1 secondary", sec_status_o, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        compare_all();

        // R2 gated start of frame
        ev(2'd0, 3'd0, 32'd0, 32'h11); step();
        chk("R2 sof without enable bit", pri_status_o, 32'd0);
        ev(2'd0, 3'd0, 32'h0040_0000, 32'h12); step();
        chk("R2 sof ch0", pri_status_o, 32'h2);
        chk("R6 irq lags status", {31'd0, irq_o}, 32'd0);
        step();
        chk("R6 irq rises", {31'd0, irq_o}, 32'd1);

        // R4 and R7: branch on ch2 while irq high
        ev(2'd2, 3'd2, 32'd0, 32'hBEEF); step();
        chk("R4 branch ch2", sec_status_o, 32'h0002_0000);
        chk("R7 subsequent flag", pri_status_o, 32'h402);
        chk("R7 frame id", frame_id_o, 32'hBEEF);

        // R3 end of frame on ch6
        ev(2'd1, 3'd6, 32'h0020_0000, 32'h5); step();
        chk("R3 eof ch6", sec_status_o, 32'h0002_2000);

        // R12 channel 7 ignored
        hold = pri_status_o;
        ev(2'd3, 3'd7, 32'd0, 32'h777); step();
        chk("R12 status unchanged", pri_status_o, hold);
        chk("R12 frame id unchanged", frame_id_o, 32'h5);

        // R5 bus error on ch5
        ev(2'd3, 3'd5, 32'd0, 32'hABCD); step();
        chk("R5 bus error record", pri_status_o & 32'h7000_0004, 32'h5000_0004);
        chk("R5 frame id", frame_id_o, 32'hABCD);

        // R8 clear bus error and channel field
        wr(2'd2, 32'h4); step();
        chk("R8 ber cleared", pri_status_o & 32'h7000_0004, 32'd0);

        // R9 write-one-to-clear limits
        wr(2'd3, 32'hFFFF_FFFF); step();
        chk("R9 clear all", sec_status_o, 32'd0);
        ev(2'd2, 3'd1, 32'd0, 32'h1); step();
        wr(2'd3, 32'hFFFF_FFFF); step();
        chk("R9 bit16 kept", sec_status_o, 32'h0001_0000);

        // R10 quick disable and last frame done
        wr(2'd0, 32'h1); step();
        wr(2'd0, 32'h0); step();
        chk("R10 quick disable", pri_status_o & 32'h80, 32'h80);
        last_frame_done = 1'b1; step();
        chk("R10 last frame", pri_status_o & 32'h1, 32'h1);

        // R11 set beats clear
        wr(2'd2, 32'h2); ev(2'd0, 3'd0, 32'h0040_0000, 32'h9); step();
        chk("R11 set wins", pri_status_o & 32'h2, 32'h2);

        // R13 reserved bits dropped
        wr(2'd0, 32'hFFFF_FFFF); step();
        chk("R13 ctrl keep", ctrl_o, 32'h1FFF_0001);
        wr(2'd1, 32'hFFFF_FFFF); step();
        chk("R13 smask keep", sec_mask_o, 32'h3F3F_3F3F);
        step();
        chk("R6 all masked", {31'd0, irq_o}, 32'd0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 1) == 0) begin
                ev(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                   $urandom() & 32'h0060_0000 | ($urandom() & 32'hFF9F_FFFF), $urandom());
            end
            if ($urandom_range(0, 3) == 0) begin
                logic [31:0] d = $urandom();
                if ($urandom_range(0, 2) == 0) d = ~d & 32'h0101_0101 ^ d;
                wr(2'($urandom_range(0, 3)), d);
            end
            if ($urandom_range(0, 19) == 0) last_frame_done = 1'b1;
            step();
        end
        summary();
    end

endmodule